// File: doc/BRIEF.md
# Converter Calibration Step Sequencer

This block orders and times the calibration passes of a successive-approximation converter. A mode input picks internal or system calibration. A two-bit selector picks one of four step orderings built from a DAC pass, a gain pass and an offset pass. When the start request arrives while the block is idle, it captures the mode and the selector. It then runs each step of the chosen ordering for a fixed number of clock cycles, and keeps `busy` high from the first step to the last.

At the start of each step the block pulses `step_go` for one cycle to the trimming stub that does the real work. The one-hot `step_onehot` shows which pass is running. The start bit `start_bit` goes high when a request is accepted and clears itself on the edge where the sequence ends. Start requests and configuration changes that arrive during a sequence have no effect. The defaults give a full internal run of 125013 cycles: 97235 for the DAC pass, 13889 for gain and 13889 for offset. A gain-only or offset-only run lasts 13889 cycles.

Top module: `cal_seq_ctrl`

## Requirements
- R1: While `rst` is high and after it is released with no request, `busy`, `start_bit`, `step_go` and `step_onehot` are all 0.
- R2: A `start_req` sampled high at a clock edge while idle makes `busy` and `start_bit` high from that edge on, so busy rises within one clock period of the request.
- R3: With `cal_system` at 0, the captured selector gives these orderings: 00 runs DAC, gain, offset; 01 runs gain, offset; 10 runs offset only; 11 runs gain only. All zeros, the reset state of the inputs, is therefore a full internal calibration.
- R4: With `cal_system` at 1, the same four selector codes give the same orderings. `step_system` is 1 during the gain and offset steps and 0 during the DAC step and while idle.
- R5: A DAC step lasts `DAC_CYC` cycles, a gain step `GAIN_CYC` cycles and an offset step `OFFS_CYC` cycles. Steps follow each other with no gap, so `busy` stays high for exactly the sum of the selected steps.
- R6: `start_bit` falls on the same edge as `busy`, and it is high in every cycle that `busy` is high.
- R7: While busy, the block ignores `start_req` and any change on `cal_system` or `cal_sel`. The running sequence keeps the configuration captured at acceptance, and no new sequence starts until the block is idle.
- R8: `step_go` is high exactly in the first cycle of each step and never while idle.
- R9: `step_onehot` bit 0 marks the DAC step, bit 1 the gain step and bit 2 the offset step. At most one bit is set, and the word is 0 when idle.
- R10: A synchronous `rst` during a sequence returns the block to idle, with `busy` and `start_bit` low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request to begin a calibration sequence |
| cal_system | input | 1 | 0 selects internal steps, 1 selects system steps |
| cal_sel | input | 2 | Selects the step ordering |
| start_bit | output | 1 | Start flag; clears itself when the sequence ends |
| busy | output | 1 | High for the whole calibration sequence |
| step_onehot | output | 3 | Current step: bit 0 DAC, bit 1 gain, bit 2 offset |
| step_system | output | 1 | The current gain or offset step is a system step |
| step_go | output | 1 | One-cycle strobe at the start of each step |

## Verification
Every output is registered. A request accepted at edge k therefore shows `busy`, `start_bit`, `step_go` and the first step in the cycle after edge k. The following steps change on the edges that fall the configured cycle counts later. `busy` and `start_bit` fall on the edge after the last cycle of the final step. The bench drives its inputs and samples the outputs just after each falling clock edge, and it indexes every sample by the number of cycles since acceptance. Bench functions compute the expected step, strobe, system flag and busy value at each index from the selector and the step lengths. Each cycle of every sequence is compared against them, including sequences where the inputs toggle at random while the block is busy.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_DAC  = 2'd1,
    ST_GAIN = 2'd2,
    ST_OFFS = 2'd3
  } step_e;

  localparam int unsigned NUM_STEPS = 3;

  // Ordering rule: which step comes first for a selector code
  function automatic step_e first_of(input logic [1:0] sel);
    case (sel)
      2'b00:   first_of = ST_DAC;
      2'b01:   first_of = ST_GAIN;
      2'b10:   first_of = ST_OFFS;
      default: first_of = ST_GAIN;
    endcase
  endfunction

  // Ordering rule: successor of a step for a selector code
  function automatic step_e after_of(input step_e cur, input logic [1:0] sel);
    case (cur)
      ST_DAC:  after_of = ST_GAIN;
      ST_GAIN: after_of = (sel[1] == 1'b0) ? ST_OFFS : ST_NONE;
      default: after_of = ST_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cal_step_timer.sv
module cal_step_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && !load) |=> cnt_zero); // R5

  AST_TIMER_LOADS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val))); // R5

endmodule

// File: rtl/cal_step_plan.sv
module cal_step_plan
  import cal_seq_pkg::*;
#(
  parameter int unsigned DAC_CYC  = 97235,
  parameter int unsigned GAIN_CYC = 13889,
  parameter int unsigned OFFS_CYC = 13889,
  parameter int unsigned CNT_W    = 17
) (
  input  logic [1:0]       req_sel,
  input  logic [1:0]       run_sel,
  input  step_e            cur_step,
  output step_e            first_step,
  output logic [CNT_W-1:0] first_len_m1,
  output step_e            next_step,
  output logic [CNT_W-1:0] next_len_m1
);

  function automatic logic [CNT_W-1:0] len_m1(input step_e s);
    case (s)
      ST_DAC:  len_m1 = CNT_W'(DAC_CYC - 1);
      ST_GAIN: len_m1 = CNT_W'(GAIN_CYC - 1);
      ST_OFFS: len_m1 = CNT_W'(OFFS_CYC - 1);
      default: len_m1 = '0;
    endcase
  endfunction

  always_comb begin
    first_step   = first_of(req_sel);
    first_len_m1 = len_m1(first_step);
    next_step    = after_of(cur_step, run_sel);
    next_len_m1  = len_m1(next_step);
  end

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int unsigned DAC_CYC  = 97235,
  parameter int unsigned GAIN_CYC = 13889,
  parameter int unsigned OFFS_CYC = 13889
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       cal_system,
  input  logic [1:0] cal_sel,
  output logic       start_bit,
  output logic       busy,
  output logic [2:0] step_onehot,
  output logic       step_system,
  output logic       step_go
);

  localparam int unsigned MAX_AB  = (DAC_CYC > GAIN_CYC) ? DAC_CYC : GAIN_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > OFFS_CYC) ? MAX_AB : OFFS_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  step_e            step_q;
  logic             cfg_sys_q;
  logic [1:0]       cfg_sel_q;
  logic             start_q;
  logic             go_q;

  step_e            first_step;
  step_e            next_step;
  logic [CNT_W-1:0] first_len_m1;
  logic [CNT_W-1:0] next_len_m1;
  logic             cnt_zero;

  // Named internal events
  logic             accept;
  logic             step_end;
  logic             seq_end;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  cal_step_plan #(
    .DAC_CYC (DAC_CYC),
    .GAIN_CYC(GAIN_CYC),
    .OFFS_CYC(OFFS_CYC),
    .CNT_W   (CNT_W)
  ) u_plan (
    .req_sel     (cal_sel),
    .run_sel     (cfg_sel_q),
    .cur_step    (step_q),
    .first_step  (first_step),
    .first_len_m1(first_len_m1),
    .next_step   (next_step),
    .next_len_m1 (next_len_m1)
  );

  assign accept   = (step_q == ST_NONE) && start_req;
  assign step_end = (step_q != ST_NONE) && cnt_zero;
  assign seq_end  = step_end && (next_step == ST_NONE);
  assign tmr_load = accept || (step_end && !seq_end);
  assign tmr_val  = accept ? first_len_m1 : next_len_m1;

  cal_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .cnt_zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= ST_NONE;
      cfg_sys_q <= 1'b0;
      cfg_sel_q <= 2'b00;
      start_q   <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      go_q <= tmr_load;
      if (accept) begin
        step_q    <= first_step;
        cfg_sys_q <= cal_system;
        cfg_sel_q <= cal_sel;
        start_q   <= 1'b1;
      end else if (step_end) begin
        step_q <= next_step;
        if (seq_end) begin
          start_q <= 1'b0;
        end
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STEPS; gi++) begin : g_onehot
      assign step_onehot[gi] = (step_q == step_e'(gi + 1));
    end
  endgenerate

  assign busy        = (step_q != ST_NONE);
  assign start_bit   = start_q;
  assign step_go     = go_q;
  assign step_system = cfg_sys_q && ((step_q == ST_GAIN) || (step_q == ST_OFFS));

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !start_bit && !step_go)); // R1

  AST_BUSY_RISES: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req) |=> (busy && start_bit)); // R2

  AST_DAC_THEN_GAIN: assert property (@(posedge clk) disable iff (rst)
    (step_onehot[0] && cnt_zero) |=> step_onehot[1]); // R3

  AST_DAC_NOT_SYSTEM: assert property (@(posedge clk) disable iff (rst)
    step_onehot[0] |-> !step_system); // R4

  AST_START_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> start_bit); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !start_bit); // R6

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !cnt_zero) |=> ($stable(step_onehot) && $stable(cfg_sel_q) && $stable(cfg_sys_q))); // R7

  AST_GO_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    step_go |-> busy); // R8

  AST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_onehot)); // R9

endmodule

// File: tb/cal_seq_ctrl_bench.sv
module cal_seq_ctrl_bench;

  localparam int DAC_N  = 23;
  localparam int GAIN_N = 11;
  localparam int OFFS_N = 7;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       start_req;
  logic       cal_system;
  logic [1:0] cal_sel;
  logic       start_bit;
  logic       busy;
  logic [2:0] step_onehot;
  logic       step_system;
  logic       step_go;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cal_seq_ctrl #(
    .DAC_CYC (DAC_N),
    .GAIN_CYC(GAIN_N),
    .OFFS_CYC(OFFS_N)
  ) u_cal_seq_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .cal_system (cal_system),
    .cal_sel    (cal_sel),
    .start_bit  (start_bit),
    .busy       (busy),
    .step_onehot(step_onehot),
    .step_system(step_system),
    .step_go    (step_go)
  );

  // 0 none, 1 DAC, 2 gain, 3 offset at cycle index i after acceptance
  function automatic int exp_step(input int sel, input int i);
    int t = i;
    case (sel)
      0: begin
        if (t < DAC_N) return 1;
        t -= DAC_N;
        if (t < GAIN_N) return 2;
        t -= GAIN_N;
        if (t < OFFS_N) return 3;
        return 0;
      end
      1: begin
        if (t < GAIN_N) return 2;
        t -= GAIN_N;
        if (t < OFFS_N) return 3;
        return 0;
      end
      2: return (t < OFFS_N) ? 3 : 0;
      default: return (t < GAIN_N) ? 2 : 0;
    endcase
  endfunction

  function automatic int exp_total(input int sel);
    case (sel)
      0: return DAC_N + GAIN_N + OFFS_N;
      1: return GAIN_N + OFFS_N;
      2: return OFFS_N;
      default: return GAIN_N;
    endcase
  endfunction

  function automatic int to_onehot(input int s);
    return (s == 0) ? 0 : (1 << (s - 1));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "busy", int'(busy), 0);
    chk(req, "start_bit", int'(start_bit), 0);
    chk(req, "step_onehot", int'(step_onehot), 0);
    chk(req, "step_go", int'(step_go), 0);
  endtask

  // One full sequence; noisy toggles inputs while busy (R7)
  task automatic run_seq(input int mode, input int sel, input bit noisy);
    int total = exp_total(sel);
    @(negedge clk); #1;
    cal_system = mode[0];
    cal_sel    = sel[1:0];
    start_req  = 1'b1;
    for (int i = 0; i <= total; i++) begin
      int s;
      int sp;
      @(negedge clk); #1;
      s  = exp_step(sel, i);
      sp = (i == 0) ? 0 : exp_step(sel, i - 1);
      chk("R2 R5", "busy", int'(busy), (i < total) ? 1 : 0);
      chk("R6", "start_bit", int'(start_bit), (i < total) ? 1 : 0);
      chk(mode ? "R4 R9" : "R3 R9", "step_onehot", int'(step_onehot), to_onehot(s));
      chk("R4", "step_system", int'(step_system), (mode != 0 && s >= 2) ? 1 : 0);
      chk("R8", "step_go", int'(step_go), (s != 0 && (i == 0 || s != sp)) ? 1 : 0);
      if (noisy && i < total - 1) begin
        start_req  = 1'($urandom % 2);
        cal_system = 1'($urandom % 2);
        cal_sel    = 2'($urandom % 4);
      end else begin
        start_req = 1'b0;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst        = 1'b1;
    start_req  = 1'b0;
    cal_system = 1'b0;
    cal_sel    = 2'b00;
    repeat (2) @(negedge clk);
    #1;
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk); #1;
    check_idle("R1");

    // R3: default all-zero inputs give the full internal sequence
    run_seq(0, 0, 1'b0);
    // Directed: every code in both modes, back to back
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        run_seq(m, c, 1'b0);
      end
    end
    // Random runs with input noise while busy (R7)
    for (int k = 0; k < 30; k++) begin
      run_seq(int'($urandom % 2), int'($urandom % 4), 1'b1);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    // R10: reset in the middle of a sequence
    @(negedge clk); #1;
    cal_system = 1'b1;
    cal_sel    = 2'b00;
    start_req  = 1'b1;
    @(negedge clk); #1;
    start_req = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk("R10", "busy before reset", int'(busy), 1);
    rst = 1'b1;
    @(negedge clk); #1;
    rst = 1'b0;
    check_idle("R10");
    @(negedge clk); #1;
    check_idle("R10");
    run_seq(1, 2, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule